// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Checker

This block sits between instruction fetch and decode in a statically scheduled pipeline that issues two instructions per cycle. Each fetched packet is an aligned pair of 32-bit instructions. The lower word is the arithmetic/branch slot (slot 0) and the upper word is the memory slot (slot 1). The block receives both slots already decoded into an operation class and register indices. It decides, in the same cycle, whether to issue both slots, to issue slot 0 alone and replay the memory slot on the next cycle, to hold the whole packet for one load-use bubble, or to reject the packet because its slots are assigned wrongly.

Fetch offers a packet with `pktValid`. The packet is consumed on a cycle where `pktReady` is also high. While a split or a stall is pending, `pktReady` stays low and fetch must keep presenting the same packet. Another pipeline stage supplies the destination of any load that issued in the previous cycle. Register 0 is hard-wired and never creates a dependency.

Top module: `dual_issue_checker`

## Requirements
- R1: The operation class is a 3-bit code: 0 = nop, 1 = ALU, 2 = branch, 3 = load, 4 = store. Slot 0 accepts nop, ALU or branch. Slot 1 accepts nop, load or store. A nop is accepted in either slot and raises no issue strobe for its slot.
- R2: A legal packet with no hazard issues in one cycle. `issue0` is high when slot 0 is not a nop, `issue1` is high when slot 1 is not a nop, and `pktReady` is high.
- R3: A packet with a wrong class in either slot raises `illegal`. This covers a load or store in slot 0, an ALU or branch op in slot 1, and codes 5 to 7. Neither slot issues, `stall` stays low, and `pktReady` is high, so the packet is dropped.
- R4: When slot 1 reads a register that the slot-0 ALU op writes, the packet is split. A load reads rs; a store reads rs and rt; an ALU op writes rd. In the first cycle only `issue0` is high and `pktReady` is low. In the next cycle only `issue1` is high and `pktReady` is high.
- R5: A load-use hazard exists when `lastLoadVld` is high and `lastLoadReg` equals a source of a slot not yet issued. ALU and branch read rs and rt; load reads rs; store reads rs and rt. On such a hazard `stall` is high, nothing issues and `pktReady` is low.
- R6: When a load-use stall and a split apply together, the stall wins. The split is evaluated again on the next cycle.
- R7: Register 0 is never a dependency. An rd of 0 causes no split, and a `lastLoadReg` of 0 causes no stall.
- R8: With `pktValid` low, `issue0`, `issue1`, `stall` and `illegal` are all low and `pktReady` is high.
- R9: A branch in slot 0 writes no register. Its rd field never causes a split.
- R10: After a split, slot 0 is never issued again for the same packet, even if a stall comes between the two halves. The record is cleared at reset and whenever a packet is consumed, so the next packet is evaluated fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | Fetch presents a packet |
| pktReady | output | 1 | Packet consumed this cycle |
| s0Op | input | 3 | Slot-0 operation class |
| s0Rd | input | REG_IDX_W | Slot-0 destination register |
| s0Rs | input | REG_IDX_W | Slot-0 first source register |
| s0Rt | input | REG_IDX_W | Slot-0 second source register |
| s1Op | input | 3 | Slot-1 operation class |
| s1Rs | input | REG_IDX_W | Slot-1 address base register |
| s1Rt | input | REG_IDX_W | Slot-1 store data register |
| lastLoadVld | input | 1 | A load issued in the previous cycle |
| lastLoadReg | input | REG_IDX_W | Destination of that load |
| issue0 | output | 1 | Slot 0 issues this cycle |
| issue1 | output | 1 | Slot 1 issues this cycle |
| stall | output | 1 | Load-use bubble this cycle |
| illegal | output | 1 | Packet rejected for wrong slot class |

## Verification
The bench builds the checker with the default of 32 registers, so every register field is five bits wide. It uses index 31 as well as low indices, so compares across the full field width are exercised. With this setting the bench can place a matching register in each of the rs and rt positions of both slots, against both the ALU destination and the prior load. It can also chain a split, a stall and the replay across three consecutive cycles on one packet.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ALU = 3'd1,
    OP_BR  = 3'd2,
    OP_LD  = 3'd3,
    OP_ST  = 3'd4
  } opClass_e;

  // strobes from control into the hazard datapath
  typedef struct packed {
    logic evalEn;
    logic skipSlot0;
  } ctrlStrobe_t;

  // results from the hazard datapath back to control
  typedef struct packed {
    logic legal;
    logic depHit;
    logic loadUse;
    logic real0;
    logic real1;
  } hazFlags_t;

endpackage

// File: rtl/pkt_hazard_dp.sv
module pkt_hazard_dp
  import dual_issue_pkg::*;
#(
  parameter int REG_IDX_W = 5
) (
  input  logic [2:0]           op0,
  input  logic [REG_IDX_W-1:0] rd0,
  input  logic [REG_IDX_W-1:0] rs0,
  input  logic [REG_IDX_W-1:0] rt0,
  input  logic [2:0]           op1,
  input  logic [REG_IDX_W-1:0] rs1,
  input  logic [REG_IDX_W-1:0] rt1,
  input  logic                 lastLoadVld,
  input  logic [REG_IDX_W-1:0] lastLoadReg,
  input  ctrlStrobe_t          strobe,
  output hazFlags_t            flags
);

  localparam int NUM_SLOTS = 2;

  logic [2:0]           opA [NUM_SLOTS];
  logic [REG_IDX_W-1:0] rsA [NUM_SLOTS];
  logic [REG_IDX_W-1:0] rtA [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] readsRs, readsRt, slotLegal, luHit, isReal;

  assign opA[0] = op0;
  assign opA[1] = op1;
  assign rsA[0] = rs0;
  assign rsA[1] = rs1;
  assign rtA[0] = rt0;
  assign rtA[1] = rt1;

  logic loadNonZero;
  assign loadNonZero = lastLoadVld && (lastLoadReg != '0);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    // source usage per operation class
    assign readsRs[s] = (opA[s] == OP_ALU) || (opA[s] == OP_BR) ||
                        (opA[s] == OP_LD)  || (opA[s] == OP_ST);
    assign readsRt[s] = (opA[s] == OP_ALU) || (opA[s] == OP_BR) ||
                        (opA[s] == OP_ST);
    assign isReal[s]  = (opA[s] != OP_NOP);
    assign luHit[s]   = loadNonZero &&
                        ((readsRs[s] && (rsA[s] == lastLoadReg)) ||
                         (readsRt[s] && (rtA[s] == lastLoadReg)));
    if (s == 0) begin : g_arith
      assign slotLegal[s] = (opA[s] == OP_NOP) || (opA[s] == OP_ALU) ||
                            (opA[s] == OP_BR);
    end else begin : g_mem
      assign slotLegal[s] = (opA[s] == OP_NOP) || (opA[s] == OP_LD) ||
                            (opA[s] == OP_ST);
    end
  end

  // only an ALU op in slot 0 produces a result, never into register 0
  logic slot0Writes;
  assign slot0Writes = (op0 == OP_ALU) && (rd0 != '0);

  logic depRaw;
  assign depRaw = slot0Writes &&
                  ((readsRs[1] && (rs1 == rd0)) || (readsRt[1] && (rt1 == rd0)));

  always_comb begin
    flags.legal   = &slotLegal;
    flags.depHit  = strobe.evalEn && depRaw;
    flags.loadUse = strobe.evalEn &&
                    ((luHit[0] && !strobe.skipSlot0) || luHit[1]);
    flags.real0   = isReal[0];
    flags.real1   = isReal[1];
  end

endmodule

// File: rtl/pkt_issue_ctrl.sv
module pkt_issue_ctrl
  import dual_issue_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktValid,
  input  hazFlags_t   flags,
  output ctrlStrobe_t strobe,
  output logic        pktReady,
  output logic        issue0,
  output logic        issue1,
  output logic        stall,
  output logic        illegal
);

  logic slot0Done;
  logic splitNow;

  always_comb begin
    strobe.evalEn    = pktValid;
    strobe.skipSlot0 = slot0Done;
    pktReady = 1'b1;
    issue0   = 1'b0;
    issue1   = 1'b0;
    stall    = 1'b0;
    illegal  = 1'b0;
    splitNow = 1'b0;
    if (pktValid) begin
      if (!flags.legal) begin
        illegal  = 1'b1;
      end else if (flags.loadUse) begin
        stall    = 1'b1;
        pktReady = 1'b0;
      end else if (flags.depHit && !slot0Done) begin
        issue0   = flags.real0;
        pktReady = 1'b0;
        splitNow = 1'b1;
      end else begin
        issue0   = flags.real0 && !slot0Done;
        issue1   = flags.real1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     slot0Done <= 1'b0;
    else if (pktValid && pktReady) slot0Done <= 1'b0;
    else if (splitNow)             slot0Done <= 1'b1;
  end

  // R4 / R10: a held first half is not issued again on the following cycle
  a_r10_no_reissue: assert property (@(posedge clk) disable iff (!rstN)
    (issue0 && !pktReady) |=> !issue0);

  a_r5_stall_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && flags.legal && flags.loadUse) |-> (stall && !issue0 && !issue1 && !pktReady));

  a_r3_illegal_dropped: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (pktReady && !issue0 && !issue1 && !stall));

  a_r2_pair_independent: assert property (@(posedge clk) disable iff (!rstN)
    (issue0 && issue1) |-> !flags.depHit);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !pktValid |-> !(issue0 || issue1 || stall || illegal));

endmodule

// File: rtl/dual_issue_checker.sv
module dual_issue_checker
  import dual_issue_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  localparam int REG_IDX_W = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pktValid,
  output logic                 pktReady,
  input  logic [2:0]           s0Op,
  input  logic [REG_IDX_W-1:0] s0Rd,
  input  logic [REG_IDX_W-1:0] s0Rs,
  input  logic [REG_IDX_W-1:0] s0Rt,
  input  logic [2:0]           s1Op,
  input  logic [REG_IDX_W-1:0] s1Rs,
  input  logic [REG_IDX_W-1:0] s1Rt,
  input  logic                 lastLoadVld,
  input  logic [REG_IDX_W-1:0] lastLoadReg,
  output logic                 issue0,
  output logic                 issue1,
  output logic                 stall,
  output logic                 illegal
);

  ctrlStrobe_t strobe;
  hazFlags_t   flags;

  pkt_hazard_dp #(.REG_IDX_W(REG_IDX_W)) dp_i (
    .op0(s0Op), .rd0(s0Rd), .rs0(s0Rs), .rt0(s0Rt),
    .op1(s1Op), .rs1(s1Rs), .rt1(s1Rt),
    .lastLoadVld(lastLoadVld), .lastLoadReg(lastLoadReg),
    .strobe(strobe), .flags(flags)
  );

  pkt_issue_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .flags(flags),
    .strobe(strobe), .pktReady(pktReady),
    .issue0(issue0), .issue1(issue1), .stall(stall), .illegal(illegal)
  );

endmodule

// File: tb/dual_issue_checker_tb.sv
module dual_issue_checker_tb_top;

  localparam logic [2:0] NOP = 3'd0, ALU = 3'd1, BR = 3'd2, LD = 3'd3, ST = 3'd4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pktValid = 1'b0;
  logic [2:0] s0Op = NOP, s1Op = NOP;
  logic [4:0] s0Rd = '0, s0Rs = '0, s0Rt = '0, s1Rs = '0, s1Rt = '0;
  logic lastLoadVld = 1'b0;
  logic [4:0] lastLoadReg = '0;
  logic pktReady, issue0, issue1, stall, illegal;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dual_issue_checker #(.NUM_REGS(32)) dut_i (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .pktReady(pktReady),
    .s0Op(s0Op), .s0Rd(s0Rd), .s0Rs(s0Rs), .s0Rt(s0Rt),
    .s1Op(s1Op), .s1Rs(s1Rs), .s1Rt(s1Rt),
    .lastLoadVld(lastLoadVld), .lastLoadReg(lastLoadReg),
    .issue0(issue0), .issue1(issue1), .stall(stall), .illegal(illegal)
  );

  task automatic expect_out(string tag, logic e0, logic e1, logic es, logic ei, logic er);
    #2;
    checks++;
    if ({issue0, issue1, stall, illegal, pktReady} !== {e0, e1, es, ei, er}) begin
      failures++;
      $display("FAIL %s: got i0=%b i1=%b st=%b il=%b rdy=%b exp i0=%b i1=%b st=%b il=%b rdy=%b",
               tag, issue0, issue1, stall, illegal, pktReady, e0, e1, es, ei, er);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pkt(logic [2:0] o0, logic [4:0] d0, logic [4:0] a0, logic [4:0] b0,
                         logic [2:0] o1, logic [4:0] a1, logic [4:0] b1);
    pktValid = 1'b1;
    s0Op = o0; s0Rd = d0; s0Rs = a0; s0Rt = b0;
    s1Op = o1; s1Rs = a1; s1Rt = b1;
  endtask

  task automatic set_load(logic v, logic [4:0] r);
    lastLoadVld = v; lastLoadReg = r;
  endtask

  task automatic t_reset_idle();
    pktValid = 1'b0;
    expect_out("R8 idle after reset", 0, 0, 0, 0, 1);
    set_load(1, 5'd3);
    expect_out("R8 idle with load pending", 0, 0, 0, 0, 1);
    set_load(0, 0);
  endtask

  task automatic t_pair();
    set_pkt(ALU, 5'd3, 5'd1, 5'd2, LD, 5'd5, 5'd0);
    expect_out("R2 alu+load pair", 1, 1, 0, 0, 1);
    step();
    set_pkt(NOP, 0, 0, 0, ST, 5'd31, 5'd30);
    expect_out("R1 nop in slot0", 0, 1, 0, 0, 1);
    step();
    set_pkt(BR, 0, 5'd4, 5'd6, NOP, 0, 0);
    expect_out("R1 nop in slot1", 1, 0, 0, 0, 1);
    step();
  endtask

  task automatic t_illegal();
    set_pkt(LD, 5'd2, 5'd1, 0, NOP, 0, 0);
    expect_out("R3 load in slot0", 0, 0, 0, 1, 1);
    step();
    set_pkt(ALU, 5'd2, 5'd1, 5'd1, ALU, 5'd1, 5'd1);
    expect_out("R3 alu in slot1", 0, 0, 0, 1, 1);
    step();
    set_pkt(3'd6, 0, 0, 0, LD, 5'd1, 0);
    expect_out("R3 undefined code", 0, 0, 0, 1, 1);
    step();
  endtask

  task automatic t_split();
    set_pkt(ALU, 5'd7, 5'd1, 5'd2, ST, 5'd2, 5'd7);
    expect_out("R4 split first half", 1, 0, 0, 0, 0);
    step();
    expect_out("R4 split replay", 0, 1, 0, 0, 1);
    step();
    set_pkt(ALU, 5'd31, 5'd1, 5'd2, LD, 5'd31, 0);
    expect_out("R10 next packet split fresh", 1, 0, 0, 0, 0);
    step();
    expect_out("R10 next packet replay", 0, 1, 0, 0, 1);
    step();
  endtask

  task automatic t_reg0_branch();
    set_pkt(ALU, 5'd0, 5'd1, 5'd2, LD, 5'd0, 0);
    expect_out("R7 rd zero no split", 1, 1, 0, 0, 1);
    step();
    set_load(1, 5'd0);
    set_pkt(ALU, 5'd3, 5'd0, 5'd0, ST, 5'd0, 5'd0);
    expect_out("R7 load reg zero no stall", 1, 1, 0, 0, 1);
    step();
    set_load(0, 0);
    set_pkt(BR, 5'd7, 5'd1, 5'd2, LD, 5'd7, 0);
    expect_out("R9 branch writes nothing", 1, 1, 0, 0, 1);
    step();
  endtask

  task automatic t_load_use();
    set_load(1, 5'd9);
    set_pkt(ALU, 5'd3, 5'd1, 5'd2, ST, 5'd4, 5'd9);
    expect_out("R5 store data load-use", 0, 0, 1, 0, 0);
    step();
    set_pkt(ALU, 5'd3, 5'd1, 5'd9, NOP, 0, 0);
    expect_out("R5 slot0 rt load-use", 0, 0, 1, 0, 0);
    step();
    set_load(0, 0);
    expect_out("R5 clears after bubble", 1, 0, 0, 0, 1);
    step();
  endtask

  task automatic t_priority();
    set_load(1, 5'd8);
    set_pkt(ALU, 5'd7, 5'd8, 5'd2, LD, 5'd7, 0);
    expect_out("R6 stall over split", 0, 0, 1, 0, 0);
    step();
    set_load(0, 0);
    expect_out("R6 split after stall", 1, 0, 0, 0, 0);
    step();
    expect_out("R6 replay after stall", 0, 1, 0, 0, 1);
    step();
  endtask

  task automatic t_stall_mid_replay();
    set_pkt(ALU, 5'd12, 5'd13, 5'd14, ST, 5'd12, 5'd11);
    expect_out("R10 split start", 1, 0, 0, 0, 0);
    step();
    set_load(1, 5'd13);
    expect_out("R5 issued slot0 source ignored", 0, 1, 0, 0, 1);
    step();
    set_pkt(ALU, 5'd12, 5'd13, 5'd14, ST, 5'd12, 5'd11);
    set_load(0, 0);
    expect_out("R10 split restart", 1, 0, 0, 0, 0);
    step();
    set_load(1, 5'd11);
    expect_out("R10 stall during replay", 0, 0, 1, 0, 0);
    step();
    set_load(0, 0);
    expect_out("R10 replay without reissue", 0, 1, 0, 0, 1);
    step();
    pktValid = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset_idle();
    t_pair();
    t_illegal();
    t_split();
    t_reg0_branch();
    t_load_use();
    t_priority();
    t_stall_mid_replay();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule